// File: doc/BRIEF.md
# DAC Command Frame SPI Transmitter

This block sits between on-chip control logic and an external multi-channel digital-to-analog converter that speaks a write-only 32-bit SPI protocol. The host hands it one request at a time over a valid/ready handshake. A request is one of four kinds: a channel sample write, a channel power-down setting, a converter configuration word, or a generic command with a caller-chosen opcode. The block builds the 32-bit frame for the request and checks that it is legal. It then shifts the frame out most significant bit first while the active-low select is held. The serial clock comes from the system clock through a parameterised divider.

The converter cannot be read back. The block therefore keeps a shadow copy of each channel's last written sample, power-down flag and power-down mode. The host reads this copy through a combinational port. A shadow entry changes only when the frame that carries the new value has been fully shifted out. A request whose sample does not fit the configured resolution, or whose channel does not exist, sends no frame and leaves the shadow copy as it was.

Top module: `dac_cmd_spi_tx`

## Requirements
- R1: Every frame is 32 bits: bits 31:28 are zero, bits 27:24 the opcode, bits 23:20 the address, bits 19:0 the payload. It is sent most significant bit first, with exactly 32 rising serial-clock edges while `spi_cs_n` is low.
- R2: A sample write (`req_kind` 0) sends opcode 3 with the requested address. Its payload is the sample shifted left by 20 minus `RES_BITS`: 4 at 16 bits, 6 at 14 bits, 8 at 12 bits.
- R3: A request is rejected when its sample is not below 2^`RES_BITS` (kinds 0 and 3), or when its address is neither below `NUM_CH` nor 15 (kind 0), or not below `NUM_CH` (kind 1). A rejected request drives `req_reject` high for the one cycle after the accepting edge. It sends no frame and changes no shadow entry.
- R4: A shadow entry keeps its old value while the frame is on the wire. It shows the new value from the cycle in which `frame_done` is high.
- R5: A sample write to address 15 updates the shadow sample of every channel.
- R6: A power-down request (`req_kind` 1) sends opcode 4 with address 0. Payload bits 7:0 hold a one-hot mask of the channel. Bits 9:8 hold the mode (0 none, 1 one kilo-ohm to ground, 2 hundred kilo-ohm to ground, 3 three-state) when `req_pd_on` is set, and are zero otherwise. The channel's shadow flag and mode take the requested values.
- R7: After reset every shadow sample is 2^(`RES_BITS`-1), every power-down mode is 1 and every power-down flag is 0. `spi_cs_n` is high, `spi_sclk` is low and `req_ready` is high.
- R8: A configuration request (`req_kind` 2) sends opcode 8 with address 0. Payload bit 0 is `req_sample[0]` (internal reference enable) and bit 1 is `req_sample[1]` (chained-device enable); all other payload bits are zero.
- R9: A generic request (`req_kind` 3) sends `req_op` and `req_addr` with the aligned sample as payload, and leaves the shadow copy unchanged.
- R10: `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. Each half period lasts `SCLK_HALF` system cycles, so select stays low for 64 x `SCLK_HALF` cycles.
- R11: `busy` is high from the edge that asserts select until the edge that releases it, and `req_ready` is low for that whole time. `frame_done` is high for the single cycle after release. Every accepted request leads either to a frame or to a reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 2 | 0 sample write, 1 power-down, 2 configuration, 3 generic |
| req_op | input | 4 | Opcode for generic requests |
| req_addr | input | 4 | Channel or address field |
| req_sample | input | 16 | Raw sample, right-aligned; configuration bits for kind 2 |
| req_pd_on | input | 1 | Channel is to be powered down |
| req_pd_mode | input | 2 | Power-down mode code |
| req_reject | output | 1 | One-cycle pulse for a rejected request |
| frame_done | output | 1 | One-cycle pulse after a frame is sent |
| busy | output | 1 | A frame is on the wire |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| rd_chan | input | CH_W | Shadow read channel select |
| rd_sample | output | 16 | Shadow sample of the selected channel |
| rd_pd_on | output | 1 | Shadow power-down flag of the selected channel |
| rd_pd_mode | output | 2 | Shadow power-down mode of the selected channel |

## Verification
The frame builder is tried with every request kind, with single-channel, top-channel and broadcast addresses, and with samples of all ones, all zeros, a single high bit and mixed patterns. Together these show whether the opcode, address and alignment fields are placed correctly and not swapped. A second instance at 12-bit resolution separates the per-resolution shift from a fixed one. It also places a sample just above the limit and one exactly at the limit on either side of the range check. Power-down requests with the flag set and then clear tell apart a mode field that follows the flag from one that is always sent. Reading the shadow copy in the middle of a frame and again at the end tells apart an early commit from a commit at release.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef enum logic [1:0] {
    KIND_WRITE   = 2'd0,
    KIND_PDOWN   = 2'd1,
    KIND_CONFIG  = 2'd2,
    KIND_GENERIC = 2'd3
  } req_kind_e;

  localparam int unsigned SAMPLE_W   = 16;
  localparam int unsigned PAYLOAD_W  = 20;
  localparam int unsigned FRAME_W    = 32;

  localparam logic [3:0] OP_WRITE_UPDATE_ONE = 4'd3;
  localparam logic [3:0] OP_POWER            = 4'd4;
  localparam logic [3:0] OP_SETUP            = 4'd8;
  localparam logic [3:0] ADDR_ALL            = 4'hF;

  typedef struct packed {
    logic [3:0]           op;
    logic [3:0]           addr;
    logic [PAYLOAD_W-1:0] payload;
  } cmd_word_t;

  // Frame: four zero bits above the opcode, address and payload.
  function automatic logic [FRAME_W-1:0] pack_frame(cmd_word_t w);
    return {4'b0000, w.op, w.addr, w.payload};
  endfunction

  // Left-align a right-justified sample into the payload field.
  function automatic logic [PAYLOAD_W-1:0] align_sample(logic [SAMPLE_W-1:0] s,
                                                        int unsigned sh);
    return PAYLOAD_W'(s) << sh;
  endfunction

  // Power-down payload: one-hot channel mask low, mode at bits 9:8.
  function automatic logic [PAYLOAD_W-1:0] pd_payload(logic [2:0] ch, logic on,
                                                      logic [1:0] mode);
    logic [1:0] m;
    m = on ? mode : 2'b00;
    return {10'b0, m, 8'b1 << ch};
  endfunction

  function automatic logic sample_fits(logic [SAMPLE_W-1:0] s, int unsigned bits);
    return (32'(s) >> bits) == 32'd0;
  endfunction

endpackage

// File: rtl/dac_cmd_compose.sv
module dac_cmd_compose
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 16
) (
  input  req_kind_e             kind,
  input  logic [3:0]            op,
  input  logic [3:0]            addr,
  input  logic [SAMPLE_W-1:0]   sample,
  input  logic                  pd_on,
  input  logic [1:0]            pd_mode,
  output logic [FRAME_W-1:0]    frame,
  output logic                  legal
);
  localparam int unsigned ALIGN_SH = PAYLOAD_W - RES_BITS;

  cmd_word_t word;
  logic      chan_ok;
  logic      fits;

  assign chan_ok = int'(addr) < NUM_CH;
  assign fits    = sample_fits(sample, RES_BITS);

  always_comb begin
    word  = '0;
    legal = 1'b0;
    case (kind)
      KIND_WRITE: begin
        word.op      = OP_WRITE_UPDATE_ONE;
        word.addr    = addr;
        word.payload = align_sample(sample, ALIGN_SH);
        legal        = fits && (chan_ok || addr == ADDR_ALL);
      end
      KIND_PDOWN: begin
        word.op      = OP_POWER;
        word.addr    = 4'h0;
        word.payload = pd_payload(addr[2:0], pd_on, pd_mode);
        legal        = chan_ok;
      end
      KIND_CONFIG: begin
        word.op      = OP_SETUP;
        word.addr    = 4'h0;
        word.payload = {18'b0, sample[1:0]};
        legal        = 1'b1;
      end
      default: begin
        word.op      = op;
        word.addr    = addr;
        word.payload = align_sample(sample, ALIGN_SH);
        legal        = fits;
      end
    endcase
  end

  assign frame = pack_frame(word);

endmodule

// File: rtl/dac_spi_serializer.sv
module dac_spi_serializer
  import dac_cmd_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               busy,
  output logic               last_edge,
  output logic               done
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  typedef enum logic {SER_IDLE, SER_RUN} ser_state_e;

  ser_state_e         state_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bitn_q;
  logic               sclk_q;
  logic               cs_n_q;
  logic               done_q;
  logic               half_tick;

  assign half_tick = (state_q == SER_RUN) && (div_q == DIV_W'(SCLK_HALF - 1));
  assign last_edge = half_tick && sclk_q && (bitn_q == BIT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      shreg_q <= '0;
      div_q   <= '0;
      bitn_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SER_IDLE: begin
          if (start) begin
            shreg_q <= frame;
            div_q   <= '0;
            bitn_q  <= '0;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b0;
            state_q <= SER_RUN;
          end
        end
        default: begin
          if (half_tick) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              if (last_edge) begin
                cs_n_q  <= 1'b1;
                done_q  <= 1'b1;
                state_q <= SER_IDLE;
              end else begin
                bitn_q  <= bitn_q + 1'b1;
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
              end
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_n_q;
  assign mosi = shreg_q[FRAME_W-1];
  assign busy = (state_q == SER_RUN);
  assign done = done_q;

endmodule

// File: rtl/dac_shadow_cache.sv
module dac_shadow_cache
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 16,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_all,
  input  logic [CH_W-1:0]     wr_chan,
  input  logic [SAMPLE_W-1:0] wr_sample,
  input  logic                pd_en,
  input  logic [CH_W-1:0]     pd_chan,
  input  logic                pd_on,
  input  logic [1:0]          pd_mode,
  input  logic [CH_W-1:0]     rd_chan,
  output logic [SAMPLE_W-1:0] rd_sample,
  output logic                rd_pd_on,
  output logic [1:0]          rd_pd_mode
);
  localparam logic [SAMPLE_W-1:0] MIDSCALE = SAMPLE_W'(1) << (RES_BITS - 1);
  localparam logic [1:0]          PD_DEFAULT = 2'd1;

  logic [SAMPLE_W-1:0] sample_q [NUM_CH];
  logic                on_q     [NUM_CH];
  logic [1:0]          mode_q   [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sample_q[g] <= MIDSCALE;
        on_q[g]     <= 1'b0;
        mode_q[g]   <= PD_DEFAULT;
      end else begin
        if (wr_en && (wr_all || wr_chan == CH_W'(g))) begin
          sample_q[g] <= wr_sample;
        end
        if (pd_en && pd_chan == CH_W'(g)) begin
          on_q[g]   <= pd_on;
          mode_q[g] <= pd_mode;
        end
      end
    end
  end

  assign rd_sample  = sample_q[rd_chan];
  assign rd_pd_on   = on_q[rd_chan];
  assign rd_pd_mode = mode_q[rd_chan];

endmodule

// File: rtl/dac_cmd_spi_tx.sv
module dac_cmd_spi_tx
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int RES_BITS  = 16,
  parameter int SCLK_HALF = 2,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic [3:0]      req_op,
  input  logic [3:0]      req_addr,
  input  logic [15:0]     req_sample,
  input  logic            req_pd_on,
  input  logic [1:0]      req_pd_mode,
  output logic            req_reject,
  output logic            frame_done,
  output logic            busy,
  output logic            spi_sclk,
  output logic            spi_cs_n,
  output logic            spi_mosi,
  input  logic [CH_W-1:0] rd_chan,
  output logic [15:0]     rd_sample,
  output logic            rd_pd_on,
  output logic [1:0]      rd_pd_mode
);
  logic [FRAME_W-1:0]  frame_w;
  logic                legal_w;
  logic                accept_ev;
  logic                start_ev;
  logic                frame_last;
  logic                rej_q;

  req_kind_e           pend_kind_q;
  logic [3:0]          pend_addr_q;
  logic [SAMPLE_W-1:0] pend_sample_q;
  logic                pend_on_q;
  logic [1:0]          pend_mode_q;

  assign req_ready = !busy;
  assign accept_ev = req_valid && req_ready;
  assign start_ev  = accept_ev && legal_w;

  dac_cmd_compose #(
    .NUM_CH  (NUM_CH),
    .RES_BITS(RES_BITS)
  ) u_compose (
    .kind   (req_kind_e'(req_kind)),
    .op     (req_op),
    .addr   (req_addr),
    .sample (req_sample),
    .pd_on  (req_pd_on),
    .pd_mode(req_pd_mode),
    .frame  (frame_w),
    .legal  (legal_w)
  );

  dac_spi_serializer #(
    .SCLK_HALF(SCLK_HALF)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ev),
    .frame    (frame_w),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .busy     (busy),
    .last_edge(frame_last),
    .done     (frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_q         <= 1'b0;
      pend_kind_q   <= KIND_CONFIG;
      pend_addr_q   <= '0;
      pend_sample_q <= '0;
      pend_on_q     <= 1'b0;
      pend_mode_q   <= '0;
    end else begin
      rej_q <= accept_ev && !legal_w;
      if (start_ev) begin
        pend_kind_q   <= req_kind_e'(req_kind);
        pend_addr_q   <= req_addr;
        pend_sample_q <= req_sample;
        pend_on_q     <= req_pd_on;
        pend_mode_q   <= req_pd_mode;
      end
    end
  end

  assign req_reject = rej_q;

  dac_shadow_cache #(
    .NUM_CH  (NUM_CH),
    .RES_BITS(RES_BITS)
  ) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (frame_last && pend_kind_q == KIND_WRITE),
    .wr_all    (pend_addr_q == ADDR_ALL),
    .wr_chan   (pend_addr_q[CH_W-1:0]),
    .wr_sample (pend_sample_q),
    .pd_en     (frame_last && pend_kind_q == KIND_PDOWN),
    .pd_chan   (pend_addr_q[CH_W-1:0]),
    .pd_on     (pend_on_q),
    .pd_mode   (pend_mode_q),
    .rd_chan   (rd_chan),
    .rd_sample (rd_sample),
    .rd_pd_on  (rd_pd_on),
    .rd_pd_mode(rd_pd_mode)
  );

endmodule

// File: rtl/dac_cmd_spi_tx_chk.sv
module dac_cmd_spi_tx_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            spi_sclk,
  input logic            spi_cs_n,
  input logic            spi_mosi,
  input logic            busy,
  input logic            frame_done,
  input logic            req_reject,
  input logic [CH_W-1:0] rd_chan,
  input logic [15:0]     rd_sample,
  input logic            frame_last,
  input logic            accept_ev
);
  logic       sclk_d;
  logic [5:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= spi_sclk;
      if (spi_cs_n) rise_cnt <= '0;
      else if (spi_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r10_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r11_busy_matches_cs: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !spi_cs_n);

  a_r11_accept_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (busy || req_reject));

  a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (spi_cs_n && $past(!spi_cs_n)));

  a_r11_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (spi_cs_n && frame_done));

  a_r3_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (spi_cs_n && !busy));

  a_r1_thirty_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (rise_cnt == 6'd32));

  a_r4_cache_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n) && $stable(rd_chan)) |-> $stable(rd_sample));

endmodule

bind dac_cmd_spi_tx dac_cmd_spi_tx_chk #(.CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .busy      (busy),
  .frame_done(frame_done),
  .req_reject(req_reject),
  .rd_chan   (rd_chan),
  .rd_sample (rd_sample),
  .frame_last(frame_last),
  .accept_ev (accept_ev)
);

// File: tb/dac_cmd_spi_tx_bench.sv
`timescale 1ns/1ps

module spi_frame_cap (
  input  logic        clk,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic [31:0] word,
  output int          nbits,
  output int          low_cycles,
  output int          bad_edges,
  output int          frames
);
  logic sclk_p = 1'b0;
  logic cs_p   = 1'b1;
  logic mosi_p = 1'b0;

  initial begin
    word = '0; nbits = 0; low_cycles = 0; bad_edges = 0; frames = 0;
  end

  always @(negedge clk) begin
    if (cs_p && !cs_n) begin
      word = '0; nbits = 0; low_cycles = 0;
    end
    if (!cs_n) begin
      low_cycles++;
      if (sclk && !sclk_p) begin
        word = {word[30:0], mosi};
        nbits++;
      end
      if (sclk && sclk_p && mosi !== mosi_p) bad_edges++;
    end
    if (cs_n && !cs_p) frames++;
    sclk_p = sclk; cs_p = cs_n; mosi_p = mosi;
  end
endmodule

module dac_cmd_spi_tx_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        va, vb;
  logic [1:0]  kind;
  logic [3:0]  op, addr;
  logic [15:0] sample;
  logic        pd_on;
  logic [1:0]  pd_mode;

  logic        rdy_a, rej_a, done_a, busy_a, sclk_a, cs_a, mosi_a, rpo_a;
  logic [2:0]  rdc_a;
  logic [15:0] rds_a;
  logic [1:0]  rpm_a;
  logic        rdy_b, rej_b, done_b, busy_b, sclk_b, cs_b, mosi_b, rpo_b;
  logic [1:0]  rdc_b;
  logic [15:0] rds_b;
  logic [1:0]  rpm_b;

  dac_cmd_spi_tx #(.NUM_CH(8), .RES_BITS(16), .SCLK_HALF(2)) u_dac_cmd_spi_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(rdy_a),
    .req_kind(kind), .req_op(op), .req_addr(addr), .req_sample(sample),
    .req_pd_on(pd_on), .req_pd_mode(pd_mode), .req_reject(rej_a),
    .frame_done(done_a), .busy(busy_a), .spi_sclk(sclk_a), .spi_cs_n(cs_a),
    .spi_mosi(mosi_a), .rd_chan(rdc_a), .rd_sample(rds_a),
    .rd_pd_on(rpo_a), .rd_pd_mode(rpm_a)
  );

  dac_cmd_spi_tx #(.NUM_CH(4), .RES_BITS(12), .SCLK_HALF(2)) u_dac_cmd_spi_tx_r12 (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rdy_b),
    .req_kind(kind), .req_op(op), .req_addr(addr), .req_sample(sample),
    .req_pd_on(pd_on), .req_pd_mode(pd_mode), .req_reject(rej_b),
    .frame_done(done_b), .busy(busy_b), .spi_sclk(sclk_b), .spi_cs_n(cs_b),
    .spi_mosi(mosi_b), .rd_chan(rdc_b), .rd_sample(rds_b),
    .rd_pd_on(rpo_b), .rd_pd_mode(rpm_b)
  );

  logic [31:0] word_a, word_b;
  int nb_a, low_a, bad_a, fr_a, nb_b, low_b, bad_b, fr_b;
  spi_frame_cap u_cap_a (.clk(clk), .sclk(sclk_a), .cs_n(cs_a), .mosi(mosi_a),
    .word(word_a), .nbits(nb_a), .low_cycles(low_a), .bad_edges(bad_a), .frames(fr_a));
  spi_frame_cap u_cap_b (.clk(clk), .sclk(sclk_b), .cs_n(cs_b), .mosi(mosi_b),
    .word(word_b), .nbits(nb_b), .low_cycles(low_b), .bad_edges(bad_b), .frames(fr_b));

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  task automatic wait_done(input bit to_b);
    int guard;
    guard = 0;
    while (!(to_b ? done_b : done_a) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    #1;
  endtask

  task automatic send(input bit to_b, input logic [1:0] k, input logic [3:0] c,
                      input logic [3:0] a, input logic [15:0] d, input logic po,
                      input logic [1:0] pm, input bit wait_end, output bit rejected);
    @(negedge clk);
    while (!(to_b ? rdy_b : rdy_a)) @(negedge clk);
    kind = k; op = c; addr = a; sample = d; pd_on = po; pd_mode = pm;
    if (to_b) vb = 1'b1; else va = 1'b1;
    @(negedge clk);
    va = 1'b0; vb = 1'b0;
    rejected = to_b ? rej_b : rej_a;
    if (!rejected && wait_end) wait_done(to_b);
  endtask

  function automatic string vtag(logic [1:0] k, logic rj);
    if (rj) return "R3";
    case (k)
      2'd0: return "R2";
      2'd1: return "R6";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  // {kind, op, addr, sample, pd_on, pd_mode, reject, frame, chk_ch, chk_sample, chk_on, chk_mode}
  localparam int NV = 12;
  localparam logic [83:0] VTAB [NV] = '{
    {2'd0,4'd0,4'd2, 16'hABCD,1'b0,2'd0,1'b0,32'h032ABCD0,3'd2,16'hABCD,1'b0,2'd1},
    {2'd0,4'd0,4'd7, 16'h0001,1'b0,2'd0,1'b0,32'h03700010,3'd7,16'h0001,1'b0,2'd1},
    {2'd0,4'd0,4'd15,16'h1234,1'b0,2'd0,1'b0,32'h03F12340,3'd0,16'h1234,1'b0,2'd1},
    {2'd0,4'd0,4'd9, 16'h5555,1'b0,2'd0,1'b1,32'h00000000,3'd1,16'h1234,1'b0,2'd1},
    {2'd1,4'd0,4'd3, 16'h0000,1'b1,2'd2,1'b0,32'h04000208,3'd3,16'h1234,1'b1,2'd2},
    {2'd1,4'd0,4'd5, 16'h0000,1'b0,2'd3,1'b0,32'h04000020,3'd5,16'h1234,1'b0,2'd3},
    {2'd1,4'd0,4'd8, 16'h0000,1'b1,2'd3,1'b1,32'h00000000,3'd0,16'h1234,1'b0,2'd1},
    {2'd2,4'd0,4'd0, 16'h0003,1'b0,2'd0,1'b0,32'h08000003,3'd3,16'h1234,1'b1,2'd2},
    {2'd2,4'd0,4'd6, 16'hFFFE,1'b0,2'd0,1'b0,32'h08000002,3'd7,16'h1234,1'b0,2'd1},
    {2'd3,4'd1,4'd4, 16'h0000,1'b0,2'd0,1'b0,32'h01400000,3'd4,16'h1234,1'b0,2'd1},
    {2'd3,4'd5,4'd15,16'hFFFF,1'b0,2'd0,1'b0,32'h05FFFFF0,3'd6,16'h1234,1'b0,2'd1},
    {2'd3,4'd7,4'd0, 16'h8000,1'b0,2'd0,1'b0,32'h07080000,3'd2,16'h1234,1'b0,2'd1}
  };

  initial begin
    bit rj;
    int fr_before;
    rst_n = 1'b0; va = 1'b0; vb = 1'b0;
    kind = '0; op = '0; addr = '0; sample = '0; pd_on = 1'b0; pd_mode = '0;
    rdc_a = '0; rdc_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk("R7 cs_n idle", {31'b0, cs_a}, 32'd1);
    chk("R7 sclk idle", {31'b0, sclk_a}, 32'd0);
    chk("R7 ready", {31'b0, rdy_a}, 32'd1);
    for (int c = 0; c < 8; c++) begin
      rdc_a = 3'(c); #1;
      chk("R7 midscale", {16'b0, rds_a}, 32'h8000);
      chk("R7 pd mode", {30'b0, rpm_a}, 32'd1);
      chk("R7 pd flag", {31'b0, rpo_a}, 32'd0);
    end
    rdc_b = 2'd3; #1;
    chk("R7 midscale 12-bit", {16'b0, rds_b}, 32'h0800);

    // R4 / R11 / R10: commit timing and wire timing
    rdc_a = 3'd1;
    send(1'b0, 2'd0, 4'd0, 4'd1, 16'h4321, 1'b0, 2'd0, 1'b0, rj);
    chk("R11 accepted", {31'b0, rj}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R4 old value mid-frame", {16'b0, rds_a}, 32'h8000);
    chk("R11 busy mid-frame", {31'b0, busy_a}, 32'd1);
    chk("R11 not ready mid-frame", {31'b0, rdy_a}, 32'd0);
    wait_done(1'b0);
    chk("R4 new value at done", {16'b0, rds_a}, 32'h4321);
    chk("R11 ready at done", {31'b0, rdy_a}, 32'd1);
    chk("R2 frame ch1", word_a, 32'h03143210);
    chk("R1 bit count", nb_a, 32'd32);
    chk("R10 select low cycles", low_a, 32'd128);

    // Table walk on the 16-bit instance
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k, pm, cpm;
      logic [3:0] c, a;
      logic [15:0] d, cv;
      logic po, rjx, cpo;
      logic [31:0] fr;
      logic [2:0] cc;
      {k, c, a, d, po, pm, rjx, fr, cc, cv, cpo, cpm} = VTAB[i];
      fr_before = fr_a;
      send(1'b0, k, c, a, d, po, pm, 1'b1, rj);
      chk({vtag(k, rjx), " reject flag"}, {31'b0, rj}, {31'b0, rjx});
      if (!rjx) begin
        chk({vtag(k, rjx), " R1 frame"}, word_a, fr);
        chk("R1 bit count", nb_a, 32'd32);
      end else begin
        repeat (3) @(negedge clk);
        chk("R3 no frame sent", fr_a, fr_before);
      end
      rdc_a = cc; #1;
      chk({vtag(k, rjx), " shadow sample"}, {16'b0, rds_a}, {16'b0, cv});
      chk({vtag(k, rjx), " shadow pd flag"}, {31'b0, rpo_a}, {31'b0, cpo});
      chk({vtag(k, rjx), " shadow pd mode"}, {30'b0, rpm_a}, {30'b0, cpm});
    end

    // R5 broadcast reached every entry
    for (int c = 0; c < 8; c++) begin
      rdc_a = 3'(c); #1;
      chk("R5 broadcast sample", {16'b0, rds_a}, 32'h1234);
    end
    chk("R10 mosi moved only while sclk low", bad_a, 32'd0);

    // 12-bit instance: range limit and alignment
    rdc_b = 2'd0;
    send(1'b1, 2'd0, 4'd0, 4'd0, 16'h1000, 1'b0, 2'd0, 1'b1, rj);
    chk("R3 over-range rejected", {31'b0, rj}, 32'd1);
    repeat (4) @(negedge clk); #1;
    chk("R3 no frame 12-bit", fr_b, 32'd0);
    chk("R3 shadow untouched", {16'b0, rds_b}, 32'h0800);
    send(1'b1, 2'd0, 4'd0, 4'd5, 16'h0010, 1'b0, 2'd0, 1'b1, rj);
    chk("R3 channel beyond count rejected", {31'b0, rj}, 32'd1);
    send(1'b1, 2'd3, 4'd2, 4'd1, 16'h2000, 1'b0, 2'd0, 1'b1, rj);
    chk("R3 R9 generic over-range rejected", {31'b0, rj}, 32'd1);
    send(1'b1, 2'd0, 4'd0, 4'd0, 16'h0FFF, 1'b0, 2'd0, 1'b1, rj);
    chk("R3 limit value accepted", {31'b0, rj}, 32'd0);
    chk("R2 12-bit alignment", word_b, 32'h030FFF00);
    chk("R4 12-bit shadow", {16'b0, rds_b}, 32'h0FFF);
    chk("R10 select low cycles 12-bit", low_b, 32'd128);

    repeat (4) @(negedge clk);
    report();
  end
endmodule